// File: doc/BRIEF.md
# Predicated Register Micro-Op Executor

This unit runs one register micro-op per clock. A micro-op names a destination register, a first source register, and a second operand. The second operand is either another register or an 8-bit immediate. The micro-op also carries an operand size and a 16-bit extension field. The unit holds a 16-entry register file and an 8-bit flag register, and it commits the result in the same cycle the op is presented.

The extension field has two meanings, chosen by the opcode. For the eight arithmetic and logic operations it is a flag mask: the low eight bits choose which flags take freshly computed values, and every other flag keeps its old value. For the move operation it is a 5-bit condition code tested against the current flags. When the test fails, the move writes nothing. The move never touches the flags. Four condition codes, and their inverses, have no defined meaning. If a move carries one of them, the unit raises a one-cycle error output and suppresses the write.

Results are merged into the destination at the operand size, so destination bits above that size survive. Compare computes flags only.

Top module: `uop_exec`

## Requirements
- R1: After reset the flag register reads zero, and with no valid op both `wb_en` and `illegal_cond` are low.
- R2: The opcodes are add=0, or=1, add-with-carry=2, and=4 and xor=6. Each writes the source-1 value combined with the second operand. Add-with-carry also adds the current CF flag.
- R3: Subtract=5 writes source 1 minus the second operand. Subtract-with-borrow=3 also subtracts the current CF flag. Compare=7 computes destination minus second operand, updates flags only, and never writes a register.
- R4: A write replaces only the low lane of the destination; destination bits above the operand size keep their value.
- R5: Flag bits are CF=0, PF=1, AF=2, ZF=3, SF=4, OF=5, ECF=6 and EZF=7. The flag operands are: first operand a, second operand b, lane result r, with top lane bit t. The second operand b is the negated second operand for subtract, subtract-with-borrow and compare. The flags are:
  - CF and ECF are majority(a[t], b[t], !r[t]).
  - AF is the same majority taken at bit 3.
  - ZF and EZF mean the lane of r is zero.
  - SF is r[t].
  - PF means r[7:0] has an even number of ones.
  - OF means a[t]==b[t] and r[t]!=a[t].
- R6: An arithmetic op updates only the flag bits set in ext[7:0]. The other flags keep their values at the next cycle.
- R7: Condition code c (ext[4:0]) has base c[3:0], and c[4]=1 inverts the result. The bases are:
  - 0 is always.
  - 1 is ECF and 2 is EZF.
  - 3 is "not (EZF clear and ZF set)".
  - 8 is OF, 9 is CF and 10 is ZF.
  - 11 is CF or ZF.
  - 12 is SF and 13 is PF.
  - 14 is SF xor OF.
  - 15 is (SF xor OF) or ZF.
- R8: Move=8 writes the second operand to the destination only when its condition holds, and it never changes the flags.
- R9: A move whose condition base is 4 to 7 (codes 4-7 and 20-23) raises `illegal_cond` in that cycle, writes nothing, and leaves the flags unchanged.
- R10: With `uop_use_imm` set, the 8-bit immediate is zero-extended to form the second operand.
- R11: Opcodes 9 to 15 write nothing and change no flag.
- R12: Size code s gives a lane of 8<<s bits, limited to DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| uop_valid | input | 1 | Micro-op present this cycle |
| uop_op | input | 4 | Opcode |
| uop_dst | input | IDX_W | Destination register index |
| uop_src1 | input | IDX_W | First source register index |
| uop_src2 | input | IDX_W | Second source register index |
| uop_imm | input | 8 | Immediate second operand |
| uop_use_imm | input | 1 | Select the immediate as the second operand |
| uop_size | input | 2 | Operand size code |
| uop_ext | input | 16 | Flag mask or condition code |
| wb_en | output | 1 | Destination write happens this cycle |
| wb_data | output | DATA_W | Merged value written to the destination |
| flags | output | 8 | Current flag register |
| illegal_cond | output | 1 | Undefined condition code on a move |

## Verification
The bench builds the unit with DATA_W=16 and four registers. With that width, all four size codes are reachable: byte lanes, full lanes, and the two codes that clamp to 16 bits. Top-bit carries, overflows and zero results then occur often under a simple operand sweep. The sweep walks 1024 operand pairs through every arithmetic opcode with rotating flag masks. After each arithmetic op it runs a predicated move whose condition code cycles through all 32 values, so every test meets many flag states. Directed steps cover the undefined codes, the unused opcodes and the zero-extended immediate.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int FLAG_N = 8;

  localparam int FB_CF  = 0;
  localparam int FB_PF  = 1;
  localparam int FB_AF  = 2;
  localparam int FB_ZF  = 3;
  localparam int FB_SF  = 4;
  localparam int FB_OF  = 5;
  localparam int FB_ECF = 6;
  localparam int FB_EZF = 7;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_OR  = 4'd1;
  localparam logic [3:0] OP_ADC = 4'd2;
  localparam logic [3:0] OP_SBB = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_SUB = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_CMP = 4'd7;
  localparam logic [3:0] OP_MOV = 4'd8;

  localparam logic [3:0] CT_ALWAYS = 4'd0;
  localparam logic [3:0] CT_ECF    = 4'd1;
  localparam logic [3:0] CT_EZF    = 4'd2;
  localparam logic [3:0] CT_EZNZ   = 4'd3;
  localparam logic [3:0] CT_OF     = 4'd8;
  localparam logic [3:0] CT_CF     = 4'd9;
  localparam logic [3:0] CT_ZF     = 4'd10;
  localparam logic [3:0] CT_CORZ   = 4'd11;
  localparam logic [3:0] CT_SF     = 4'd12;
  localparam logic [3:0] CT_PF     = 4'd13;
  localparam logic [3:0] CT_SXO    = 4'd14;
  localparam logic [3:0] CT_SXOZ   = 4'd15;
endpackage

// File: rtl/uop_cond_eval.sv
module uop_cond_eval
  import uop_pkg::*;
(
  input  logic [FLAG_N-1:0] flags_in,
  input  logic [4:0]        code,
  output logic              pass,
  output logic              undef
);
  logic base;
  logic cf, zf, sf, of, pf, ecf, ezf;

  assign cf  = flags_in[FB_CF];
  assign zf  = flags_in[FB_ZF];
  assign sf  = flags_in[FB_SF];
  assign of  = flags_in[FB_OF];
  assign pf  = flags_in[FB_PF];
  assign ecf = flags_in[FB_ECF];
  assign ezf = flags_in[FB_EZF];

  always_comb begin
    base  = 1'b0;
    undef = 1'b0;
    case (code[3:0])
      CT_ALWAYS: base = 1'b1;
      CT_ECF:    base = ecf;
      CT_EZF:    base = ezf;
      CT_EZNZ:   base = ~(~ezf & zf);
      4'd4, 4'd5, 4'd6, 4'd7: undef = 1'b1;
      CT_OF:     base = of;
      CT_CF:     base = cf;
      CT_ZF:     base = zf;
      CT_CORZ:   base = cf | zf;
      CT_SF:     base = sf;
      CT_PF:     base = pf;
      CT_SXO:    base = sf ^ of;
      CT_SXOZ:   base = (sf ^ of) | zf;
      default:   base = 1'b0;
    endcase
    // the inversion bit folds codes 16..31 onto 0..15
    pass = (base ^ code[4]) & ~undef;
  end

  // R7: code 0 always passes, code 16 never does
  always_comb begin
    if (code == 5'd0)  assert_always_passes_R7: assert (pass);
    if (code == 5'd16) assert_never_passes_R7:  assert (!pass);
  end
endmodule

// File: rtl/uop_flag_gen.sv
module uop_flag_gen
  import uop_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] lane_mask,
  output logic [FLAG_N-1:0] gen
);
  localparam int TW = $clog2(DATA_W);

  function automatic logic [TW-1:0] lane_top(input logic [1:0] sz);
    int w;
    w = 8 << sz;
    if (w > DATA_W) w = DATA_W;
    return TW'(w - 1);
  endfunction

  function automatic logic [DATA_W-1:0] carry_vec(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b,
                                                  input logic [DATA_W-1:0] r);
    return (a & b) | ((a | b) & ~r);
  endfunction

  function automatic logic [DATA_W-1:0] ovf_vec(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b,
                                                input logic [DATA_W-1:0] r);
    return (a ^ ~b) & (a ^ r);
  endfunction

  logic [TW-1:0]     top;
  logic [DATA_W-1:0] cv, ov;
  logic              zero;

  always_comb begin
    top       = lane_top(size);
    lane_mask = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(top));
    cv        = carry_vec(opa, opb, res);
    ov        = ovf_vec(opa, opb, res);
    zero      = ((res & lane_mask) == '0);
    gen          = '0;
    gen[FB_CF]   = cv[top];
    gen[FB_ECF]  = cv[top];
    gen[FB_AF]   = cv[3];
    gen[FB_ZF]   = zero;
    gen[FB_EZF]  = zero;
    gen[FB_SF]   = res[top];
    gen[FB_PF]   = ~^res[7:0];
    gen[FB_OF]   = ov[top];
  end
endmodule

// File: rtl/uop_regfile.sv
module uop_regfile #(
  parameter int NREGS  = 16,
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  input  logic [IDX_W-1:0]  ridx_b,
  input  logic [IDX_W-1:0]  ridx_d,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  output logic [DATA_W-1:0] rdata_d
);
  logic [DATA_W-1:0] mem [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we && widx == IDX_W'(g)) q <= wdata;
    end
    assign mem[g] = q;
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];
  assign rdata_d = mem[ridx_d];
endmodule

// File: rtl/uop_exec.sv
module uop_exec
  import uop_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NREGS  = 16,
  parameter int IDX_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uop_valid,
  input  logic [3:0]        uop_op,
  input  logic [IDX_W-1:0]  uop_dst,
  input  logic [IDX_W-1:0]  uop_src1,
  input  logic [IDX_W-1:0]  uop_src2,
  input  logic [7:0]        uop_imm,
  input  logic              uop_use_imm,
  input  logic [1:0]        uop_size,
  input  logic [15:0]       uop_ext,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_data,
  output logic [7:0]        flags,
  output logic              illegal_cond
);
  logic [FLAG_N-1:0] flags_q, flags_d, flag_gen;
  logic [DATA_W-1:0] src1_v, src2_v, dst_old, op2, cin_v, raw;
  logic [DATA_W-1:0] fa, fb, lane;
  logic              is_arith, is_mov, is_cmp, is_negb;
  logic              cond_pass, cond_undef;
  logic              flag_we;
  logic [4:0]        cond_code;
  logic              unused_ext_hi;

  assign unused_ext_hi = ^uop_ext[15:8];

  uop_regfile #(.NREGS(NREGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .we(wb_en), .widx(uop_dst), .wdata(wb_data),
    .ridx_a(uop_src1), .ridx_b(uop_src2), .ridx_d(uop_dst),
    .rdata_a(src1_v), .rdata_b(src2_v), .rdata_d(dst_old)
  );

  // operand selection and raw result
  assign op2      = uop_use_imm ? {{(DATA_W-8){1'b0}}, uop_imm} : src2_v;
  assign cin_v    = {{(DATA_W-1){1'b0}}, flags_q[FB_CF]};
  assign is_arith = (uop_op <= OP_CMP);
  assign is_mov   = (uop_op == OP_MOV);
  assign is_cmp   = (uop_op == OP_CMP);
  assign is_negb  = (uop_op == OP_SUB) || (uop_op == OP_SBB) || is_cmp;

  always_comb begin
    case (uop_op)
      OP_ADD:  raw = src1_v + op2;
      OP_OR:   raw = src1_v | op2;
      OP_ADC:  raw = src1_v + op2 + cin_v;
      OP_SBB:  raw = src1_v - op2 - cin_v;
      OP_AND:  raw = src1_v & op2;
      OP_SUB:  raw = src1_v - op2;
      OP_XOR:  raw = src1_v ^ op2;
      OP_CMP:  raw = dst_old - op2;
      OP_MOV:  raw = op2;
      default: raw = '0;
    endcase
  end

  assign fa = is_cmp ? dst_old : src1_v;
  assign fb = is_negb ? -op2 : op2;

  uop_flag_gen #(.DATA_W(DATA_W)) u_fg (
    .opa(fa), .opb(fb), .res(raw), .size(uop_size),
    .lane_mask(lane), .gen(flag_gen)
  );

  // predication: only the move reads the extension field as a test
  assign cond_code = is_mov ? uop_ext[4:0] : 5'd0;

  uop_cond_eval u_ce (
    .flags_in(flags_q), .code(cond_code),
    .pass(cond_pass), .undef(cond_undef)
  );

  assign illegal_cond = uop_valid & is_mov & cond_undef;
  assign wb_en        = uop_valid & ((is_arith & ~is_cmp) | (is_mov & cond_pass));
  assign wb_data      = (dst_old & ~lane) | (raw & lane);
  assign flag_we      = uop_valid & is_arith;
  assign flags_d      = (flags_q & ~uop_ext[7:0]) | (flag_gen & uop_ext[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_we) flags_q <= flags_d;
  end

  assign flags = flags_q;

  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && is_cmp) |-> !wb_en);
  assert_mov_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && is_mov) |=> $stable(flags));
  assert_illegal_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cond |-> !wb_en);
  assert_mask_limits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |=> ((flags ^ $past(flags)) & ~$past(uop_ext[7:0])) == 8'h00);
  assert_unused_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_op > OP_MOV) |-> !wb_en);
endmodule

// File: tb/sim_uop_exec.sv
`timescale 1ns/1ps
module sim_uop_exec;
  localparam int DW = 16;
  localparam int NR = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          uop_valid = 1'b0;
  logic [3:0]    uop_op = 4'd0;
  logic [IW-1:0] uop_dst = '0, uop_src1 = '0, uop_src2 = '0;
  logic [7:0]    uop_imm = 8'd0;
  logic          uop_use_imm = 1'b0;
  logic [1:0]    uop_size = 2'd0;
  logic [15:0]   uop_ext = 16'd0;
  logic          wb_en, illegal_cond;
  logic [DW-1:0] wb_data;
  logic [7:0]    flags;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [DW-1:0] mregs [NR];
  logic [7:0]    mflags = 8'h00;

  always #4 clk = ~clk;

  uop_exec #(.DATA_W(DW), .NREGS(NR), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_op(uop_op),
    .uop_dst(uop_dst), .uop_src1(uop_src1), .uop_src2(uop_src2),
    .uop_imm(uop_imm), .uop_use_imm(uop_use_imm), .uop_size(uop_size),
    .uop_ext(uop_ext), .wb_en(wb_en), .wb_data(wb_data), .flags(flags),
    .illegal_cond(illegal_cond)
  );

  function automatic int lane_w(input logic [1:0] sz);
    int w = 8 << sz;
    return (w > DW) ? DW : w;
  endfunction

  // R7 truth table restated from the requirement text
  function automatic logic [1:0] cond_model(input logic [4:0] c, input logic [7:0] f);
    logic t;
    logic bad_c;
    bad_c = 1'b0;
    t = 1'b0;
    if (c[3:0] == 0) t = 1;
    else if (c[3:0] == 1) t = f[6];
    else if (c[3:0] == 2) t = f[7];
    else if (c[3:0] == 3) t = !(f[7] == 0 && f[3] == 1);
    else if (c[3:0] < 8) bad_c = 1;
    else if (c[3:0] == 8) t = f[5];
    else if (c[3:0] == 9) t = f[0];
    else if (c[3:0] == 10) t = f[3];
    else if (c[3:0] == 11) t = f[0] || f[3];
    else if (c[3:0] == 12) t = f[4];
    else if (c[3:0] == 13) t = f[1];
    else if (c[3:0] == 14) t = f[4] != f[5];
    else t = (f[4] != f[5]) || f[3];
    if (c[4]) t = !t;
    return {bad_c, t && !bad_c};
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [IW-1:0] d, input logic [IW-1:0] s1,
                        input logic [IW-1:0] s2, input logic [7:0] imm, input logic ui,
                        input logic [1:0] sz, input logic [15:0] ext, input string tag);
    int w, t;
    logic [DW-1:0] av, bv, dv, res, fa, fb, fr, lm, merged;
    logic [7:0] g, nf;
    logic [1:0] cm;
    logic exp_we, exp_ill;
    w  = lane_w(sz);
    t  = w - 1;
    lm = (w >= DW) ? {DW{1'b1}} : DW'((1 << w) - 1);
    av = mregs[s1];
    bv = ui ? {8'h00, imm} : mregs[s2];
    dv = mregs[d];
    fa = av;
    fb = bv;
    case (op)
      0: res = av + bv;
      1: res = av | bv;
      2: res = av + bv + DW'(mflags[0]);
      3: begin res = av - bv - DW'(mflags[0]); fb = 0 - bv; end
      4: res = av & bv;
      5: begin res = av - bv; fb = 0 - bv; end
      6: res = av ^ bv;
      7: begin res = dv - bv; fa = dv; fb = 0 - bv; end
      8: res = bv;
      default: res = '0;
    endcase
    fr = res;
    g[0] = $countones({fa[t], fb[t], ~fr[t]}) >= 2;
    g[6] = g[0];
    g[2] = $countones({fa[3], fb[3], ~fr[3]}) >= 2;
    g[3] = (fr & lm) == 0;
    g[7] = g[3];
    g[4] = fr[t];
    g[1] = ($countones(fr[7:0]) % 2) == 0;
    g[5] = (fa[t] == fb[t]) && (fr[t] != fa[t]);
    cm = cond_model(ext[4:0], mflags);
    exp_ill = (op == 8) && cm[1];
    exp_we  = (op < 7) || ((op == 8) && cm[0]);
    merged  = (dv & ~lm) | (res & lm);
    nf = (op <= 7) ? ((mflags & ~ext[7:0]) | (g & ext[7:0])) : mflags;

    @(negedge clk);
    uop_valid = 1; uop_op = op; uop_dst = d; uop_src1 = s1; uop_src2 = s2;
    uop_imm = imm; uop_use_imm = ui; uop_size = sz; uop_ext = ext;
    #1;
    total++;
    if (wb_en !== exp_we || illegal_cond !== exp_ill || (exp_we && wb_data !== merged)) begin
      bad++;
      $display("FAIL %s op=%0d ext=%h: we=%b ill=%b data=%h, expected we=%b ill=%b data=%h",
               tag, op, ext, wb_en, illegal_cond, wb_data, exp_we, exp_ill, merged);
    end
    @(posedge clk);
    #1;
    total++;
    if (flags !== nf) begin
      bad++;
      $display("FAIL R5 R6 op=%0d mask=%h: flags=%h expected %h", op, ext[7:0], flags, nf);
    end
    if (exp_we) mregs[d] = merged;
    mflags = nf;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (flags !== 8'h00 || wb_en !== 1'b0 || illegal_cond !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: flags=%h we=%b ill=%b expected 00 0 0", flags, wb_en, illegal_cond);
    end
    @(negedge clk);
    rst_n = 1;

    // R10: full-width immediate moves load every register, immediate zero-extended
    for (int r = 0; r < NR; r++) run_op(4'd8, IW'(r), 0, 0, 8'hF0 + 8'(r), 1, 2'd1, 16'h0000, "R10 R8");
    run_op(4'd8, 0, 0, 0, 8'hFF, 1, 2'd3, 16'h0000, "R10 R12");

    // R4: byte-lane writes keep the upper byte
    run_op(4'd0, 1, 1, 1, 8'h00, 0, 2'd0, 16'h00FF, "R4 R2");
    run_op(4'd0, 1, 1, 1, 8'h00, 0, 2'd0, 16'h00FF, "R4 R2");

    // R9: undefined condition codes and their inverses
    for (int c = 4; c < 8; c++) begin
      run_op(4'd8, 0, 0, 3, 8'h00, 0, 2'd1, 16'(c), "R9");
      run_op(4'd8, 0, 0, 3, 8'h00, 0, 2'd1, 16'(c + 16), "R9");
    end

    // R11: unused opcodes with a full mask
    for (int o = 9; o < 16; o++) run_op(4'(o), 2, 1, 3, 8'h5A, 1, 2'd1, 16'hFFFF, "R11");

    // R7: always and never
    run_op(4'd8, 0, 0, 2, 8'h00, 0, 2'd1, 16'd0, "R7 R8");
    run_op(4'd8, 0, 0, 2, 8'h00, 0, 2'd1, 16'd16, "R7 R8");

    // sweep: all arithmetic ops across sizes, masks and all 32 condition codes
    for (int i = 0; i < 1024; i++) begin
      logic [7:0] a, b;
      logic [1:0] sz;
      a  = 8'(i);
      b  = 8'(i * 53 + 17);
      sz = 2'(i >> 8);
      run_op(4'd8, 1, 0, 0, a, 1, 2'd1, 16'd0, "R10");
      run_op(4'd8, 2, 0, 0, b, 1, 2'd1, 16'd0, "R10");
      for (int op = 0; op < 8; op++) begin
        logic [15:0] msk;
        string tg;
        msk = ((op + i) % 8 == 0) ? 16'h00FF : 16'((i * 7 + op * 29) & 255);
        tg  = (op == 3 || op == 5 || op == 7) ? "R3 R12" : "R2 R12";
        run_op(4'(op), 3, op[1] ? 2'd3 : 2'd1, 2, b, 1'(op) ^ 1'(i), sz, msk, tg);
        run_op(4'd8, 0, 0, 3, 8'h00, 0, 2'(i + op), 16'((i + op) % 32), "R7 R8 R4");
      end
    end

    uop_valid = 0;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule